// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block runs the transfer lifecycle of a single DMA channel. Software programs a unit count, a unit size and a request source. The block then issues one transfer-unit command at a time on a valid/ready command port. A downstream bus engine performs the actual bus cycles and acknowledges each unit by taking the command. Every acknowledged unit lowers the remaining count by one.

The channel runs only while it is permitted: both the channel and global enables are high, and the end flag, the address-error flag and the NMI flag are all low. Units are requested either automatically or by an external request line held high. When the count reaches zero the channel stops normally. It sets a sticky end flag, and can raise a one-cycle end interrupt. If the permission is lost for any other reason, the channel aborts. The outstanding command is withdrawn, the count is left as it was, no interrupt is raised and a one-cycle abort pulse is produced.

The command port follows valid/ready rules with one exception. Once `unit_valid` is high, the command and `unit_bytes` stay unchanged until a cycle in which `unit_ready` is high. The only way a command leaves without that cycle is an abort, which withdraws it. A command is taken in a cycle where valid, ready and the permission are all high.

Top module: `dma_xfer_seq`

## Requirements
- R1: No command is issued, and an outstanding command is withdrawn on the next cycle, unless all of these hold: `ch_en`=1, `glob_en`=1, `end_flag`=0, `addr_err`=0 and `nmi_flag`=0.
- R2: With `auto_mode`=1, a permitted channel with a nonzero count issues commands without any external request.
- R3: With `auto_mode`=0, a new command is issued only while `ext_req` is 1.
- R4: `unit_bytes` encodes `size_sel` as follows: 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 32. The size is captured when the command is issued.
- R5: While `unit_valid`=1 and `unit_ready`=0 with the channel permitted, the command stays valid and `unit_bytes` stays stable.
- R6: Each taken command lowers `count` by exactly one.
- R7: When the last unit is taken, `count` becomes 0, `end_flag` is set and no further command is issued.
- R8: On normal end, `end_irq` pulses high for exactly one cycle, and only when `irq_en`=1. It never pulses without `end_flag` set.
- R9: Losing the permission with a nonzero count and no normal end produces a one-cycle `abort_evt`. It leaves `count` unchanged, does not set `end_flag` and does not raise `end_irq`. Work resumes from the remaining count once the permission returns.
- R10: `end_flag` stays set until a `te_clr` pulse, and blocks any restart until then.
- R11: `cnt_load` writes `count_in` only while no command is outstanding. A count of 0 issues nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_en | input | 1 | Channel enable |
| glob_en | input | 1 | Global enable for all channels |
| addr_err | input | 1 | Address-error flag |
| nmi_flag | input | 1 | NMI flag |
| auto_mode | input | 1 | 1: automatic requests, 0: external request line |
| ext_req | input | 1 | External request, level |
| irq_en | input | 1 | End interrupt enable |
| size_sel | input | 2 | Unit size code |
| cnt_load | input | 1 | Load `count_in` into the count |
| count_in | input | CNT_W | Programmed unit count |
| te_clr | input | 1 | Clear the end flag |
| unit_valid | output | 1 | Transfer-unit command valid |
| unit_ready | input | 1 | Unit completion handshake from the bus engine |
| unit_bytes | output | 6 | Byte count of the commanded unit |
| count | output | CNT_W | Remaining unit count |
| end_flag | output | 1 | Sticky normal-end flag |
| end_irq | output | 1 | One-cycle end interrupt |
| abort_evt | output | 1 | One-cycle abort indication |

## Verification
The assertions rely on three assumptions about the inputs. All inputs are synchronous to `clk`. `cnt_load` is only meaningful while the channel is idle. The bus engine may hold `unit_ready` high for any length of time. The bench drives every input on the falling edge, loads counts only when no command is outstanding, and pulses `te_clr` and `cnt_load` for single cycles. It applies back-pressure by holding `unit_ready` low across the abort scenarios, so that a command is outstanding when the permission drops.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_WORD  = 2'b01,
    SZ_LONG  = 2'b10,
    SZ_BLK32 = 2'b11
  } unit_size_e;

  localparam int BYTES_W = 6;

  function automatic logic [BYTES_W-1:0] size_to_bytes(input logic [1:0] code);
    unit_size_e sz;
    sz = unit_size_e'(code);
    case (sz)
      SZ_BYTE:  size_to_bytes = 6'd1;
      SZ_WORD:  size_to_bytes = 6'd2;
      SZ_LONG:  size_to_bytes = 6'd4;
      default:  size_to_bytes = 6'd32;
    endcase
  endfunction
endpackage

// File: rtl/dma_seq_gate.sv
module dma_seq_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic ch_en,
  input  logic glob_en,
  input  logic end_flag,
  input  logic addr_err,
  input  logic nmi_flag,
  input  logic auto_mode,
  input  logic ext_req,
  input  logic cnt_nz,
  output logic permit,
  output logic want,
  output logic abort_evt
);
  logic perm_q;

  assign permit = ch_en & glob_en & ~end_flag & ~addr_err & ~nmi_flag;
  assign want   = permit & cnt_nz & (auto_mode | ext_req);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      perm_q    <= 1'b0;
      abort_evt <= 1'b0;
    end else begin
      perm_q    <= permit;
      abort_evt <= perm_q & ~permit & cnt_nz & ~end_flag;
    end
  end

  assert_abort_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> !abort_evt);
endmodule

// File: rtl/dma_seq_count.sv
module dma_seq_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  input  logic             te_clr,
  input  logic             irq_en,
  output logic [CNT_W-1:0] count,
  output logic             cnt_nz,
  output logic             end_flag,
  output logic             end_irq
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic last_unit;
  assign last_unit = dec & (count == ONE);
  assign cnt_nz    = (count != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count    <= '0;
      end_flag <= 1'b0;
      end_irq  <= 1'b0;
    end else begin
      end_irq <= last_unit & irq_en;
      if (load)
        count <= load_val;
      else if (dec)
        count <= count - ONE;
      if (last_unit)
        end_flag <= 1'b1;
      else if (te_clr)
        end_flag <= 1'b0;
    end
  end

  assert_dec_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dec && !load |=> count == $past(count) - ONE);
  assert_irq_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    end_irq |=> !end_irq);
  assert_irq_needs_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    end_irq |-> end_flag);
  assert_end_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    end_flag && !te_clr |=> end_flag);
endmodule

// File: rtl/dma_seq_issue.sv
module dma_seq_issue
  import dma_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               permit,
  input  logic               want,
  input  logic [1:0]         size_sel,
  input  logic               unit_ready,
  output logic               unit_valid,
  output logic [BYTES_W-1:0] unit_bytes,
  output logic               taken
);
  assign taken = unit_valid & unit_ready & permit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unit_valid <= 1'b0;
      unit_bytes <= '0;
    end else if (!permit) begin
      unit_valid <= 1'b0;
    end else if (unit_valid) begin
      if (unit_ready) unit_valid <= 1'b0;
    end else if (want) begin
      unit_valid <= 1'b1;
      unit_bytes <= size_to_bytes(size_sel);
    end
  end

  assert_gate_blocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !permit |=> !unit_valid);
  assert_cmd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    unit_valid && !unit_ready && permit |=> unit_valid && $stable(unit_bytes));
endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ch_en,
  input  logic             glob_en,
  input  logic             addr_err,
  input  logic             nmi_flag,
  input  logic             auto_mode,
  input  logic             ext_req,
  input  logic             irq_en,
  input  logic [1:0]       size_sel,
  input  logic             cnt_load,
  input  logic [CNT_W-1:0] count_in,
  input  logic             te_clr,
  output logic             unit_valid,
  input  logic             unit_ready,
  output logic [5:0]       unit_bytes,
  output logic [CNT_W-1:0] count,
  output logic             end_flag,
  output logic             end_irq,
  output logic             abort_evt
);
  logic permit, want, taken, cnt_nz, load_ok;

  assign load_ok = cnt_load & ~unit_valid;

  dma_seq_gate u_gate (
    .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .glob_en(glob_en),
    .end_flag(end_flag), .addr_err(addr_err), .nmi_flag(nmi_flag),
    .auto_mode(auto_mode), .ext_req(ext_req), .cnt_nz(cnt_nz),
    .permit(permit), .want(want), .abort_evt(abort_evt)
  );

  dma_seq_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .load(load_ok), .load_val(count_in),
    .dec(taken), .te_clr(te_clr), .irq_en(irq_en), .count(count),
    .cnt_nz(cnt_nz), .end_flag(end_flag), .end_irq(end_irq)
  );

  dma_seq_issue u_issue (
    .clk(clk), .rst_n(rst_n), .permit(permit), .want(want),
    .size_sel(size_sel), .unit_ready(unit_ready), .unit_valid(unit_valid),
    .unit_bytes(unit_bytes), .taken(taken)
  );

  assert_abort_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !permit && !load_ok |=> $stable(count));
  assert_no_cmd_at_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    unit_valid |-> count != '0);
  assert_end_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    end_flag |-> !unit_valid);
endmodule

// File: tb/dma_xfer_seq_tb_top.sv
`timescale 1ns/1ps
module dma_xfer_seq_tb_top;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ch_en = 0, glob_en = 0, addr_err = 0, nmi_flag = 0;
  logic auto_mode = 0, ext_req = 0, irq_en = 0, cnt_load = 0, te_clr = 0;
  logic unit_ready = 0;
  logic [1:0] size_sel = 2'b00;
  logic [CNT_W-1:0] count_in = '0;
  logic unit_valid, end_flag, end_irq, abort_evt;
  logic [5:0] unit_bytes;
  logic [CNT_W-1:0] count;

  int checks = 0, errors = 0, irq_seen = 0;
  bit finished = 0;
  logic [5:0] exp_q[$];

  always #4 clk = ~clk;

  dma_xfer_seq #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .glob_en(glob_en),
    .addr_err(addr_err), .nmi_flag(nmi_flag), .auto_mode(auto_mode),
    .ext_req(ext_req), .irq_en(irq_en), .size_sel(size_sel),
    .cnt_load(cnt_load), .count_in(count_in), .te_clr(te_clr),
    .unit_valid(unit_valid), .unit_ready(unit_ready), .unit_bytes(unit_bytes),
    .count(count), .end_flag(end_flag), .end_irq(end_irq), .abort_evt(abort_evt)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_units(input int n, input logic [5:0] b);
    for (int i = 0; i < n; i++) exp_q.push_back(b);
  endtask

  task automatic load_cnt(input int v);
    count_in = CNT_W'(v); cnt_load = 1; cyc(1); cnt_load = 0;
  endtask

  task automatic clr_end();
    te_clr = 1; cyc(1); te_clr = 0;
  endtask

  // monitor: takes a unit in the cycle before the edge that completes it
  always @(negedge clk) begin
    if (rst_n && end_irq) irq_seen++;
    if (rst_n && unit_valid && unit_ready && !addr_err && !nmi_flag && ch_en && glob_en) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R1 unexpected unit actual=%0d expected=none", unit_bytes);
      end else begin
        logic [5:0] e;
        e = exp_q.pop_front();
        if (unit_bytes != e) begin
          errors++;
          $display("FAIL R4 unit_bytes actual=%0d expected=%0d", unit_bytes, e);
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 50000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(1);
    chk("R1 reset valid", unit_valid, 0);
    chk("R10 reset end_flag", end_flag, 0);
    chk("R8 reset irq", end_irq, 0);
    chk("R11 reset count", count, 0);

    // auto mode, 3 longwords, interrupt on
    size_sel = 2'b10; irq_en = 1; auto_mode = 1; unit_ready = 1;
    load_cnt(3);
    push_units(3, 6'd4);
    ch_en = 1; glob_en = 1;
    cyc(12);
    chk("R2 queue drained", exp_q.size(), 0);
    chk("R6 count", count, 0);
    chk("R7 end_flag", end_flag, 1);
    chk("R7 idle after end", unit_valid, 0);
    chk("R8 irq count", irq_seen, 1);

    // end flag blocks restart
    size_sel = 2'b11; irq_en = 0;
    load_cnt(2);
    cyc(10);
    chk("R10 blocked count", count, 2);
    chk("R10 blocked valid", unit_valid, 0);
    push_units(2, 6'd32);
    clr_end();
    cyc(10);
    chk("R4 blk32 drained", exp_q.size(), 0);
    chk("R7 end again", end_flag, 1);
    chk("R8 no irq when disabled", irq_seen, 1);

    // enables and nmi block start; external request mode
    glob_en = 0;
    clr_end();
    load_cnt(4);
    cyc(6);
    chk("R1 glob_en low valid", unit_valid, 0);
    chk("R1 glob_en low count", count, 4);
    glob_en = 1; nmi_flag = 1;
    cyc(6);
    chk("R1 nmi valid", unit_valid, 0);
    nmi_flag = 0; auto_mode = 0; ext_req = 0;
    cyc(6);
    chk("R3 no ext_req valid", unit_valid, 0);
    chk("R3 no ext_req count", count, 4);
    size_sel = 2'b00;
    push_units(4, 6'd1);
    ext_req = 1;
    cyc(12);
    ext_req = 0;
    chk("R3 ext count", count, 0);
    chk("R3 ext drained", exp_q.size(), 0);

    // back-pressure then address-error abort
    auto_mode = 1; irq_en = 1; unit_ready = 0; size_sel = 2'b01;
    clr_end();
    load_cnt(3);
    cyc(5);
    chk("R5 valid held", unit_valid, 1);
    chk("R5 bytes", unit_bytes, 2);
    size_sel = 2'b11;
    cyc(3);
    chk("R5 bytes stable", unit_bytes, 2);
    addr_err = 1;
    cyc(1);
    chk("R9 abort pulse", abort_evt, 1);
    chk("R9 withdrawn", unit_valid, 0);
    chk("R9 count kept", count, 3);
    chk("R9 no end", end_flag, 0);
    cyc(1);
    chk("R9 pulse one cycle", abort_evt, 0);
    addr_err = 0; size_sel = 2'b01;
    push_units(3, 6'd2);
    unit_ready = 1;
    cyc(10);
    chk("R9 resumed count", count, 0);
    chk("R8 irq after resume", irq_seen, 2);

    // channel-enable and nmi abort, load ignored while busy
    unit_ready = 0; size_sel = 2'b00;
    clr_end();
    load_cnt(4);
    cyc(4);
    count_in = 16'd9; cnt_load = 1; cyc(1); cnt_load = 0;
    chk("R11 load ignored busy", count, 4);
    ch_en = 0;
    cyc(1);
    chk("R9 ch_en abort", abort_evt, 1);
    chk("R9 ch_en count", count, 4);
    ch_en = 1;
    cyc(3);
    nmi_flag = 1;
    cyc(1);
    chk("R9 nmi abort", abort_evt, 1);
    chk("R9 nmi count", count, 4);
    chk("R9 irq none", irq_seen, 2);
    nmi_flag = 0;
    push_units(4, 6'd1);
    unit_ready = 1;
    cyc(12);
    chk("R6 final count", count, 0);

    // zero count issues nothing
    clr_end();
    cyc(6);
    chk("R11 zero count valid", unit_valid, 0);
    chk("R11 zero count end", end_flag, 0);
    chk("R1 scoreboard empty", exp_q.size(), 0);
    finish_run();
  end
endmodule